// File: doc/BRIEF.md
# Page Entry Reference/Change Bit Updater

This block runs once per successful address translation. It takes the 64-bit leaf page entry that the table walk found, the memory address that entry came from, the kind of access (load, store or instruction fetch) and the permission set that the protection check granted. From these it forms an updated entry with the reference bit set, and for a store also the change bit. It writes the updated entry back to memory only when at least one bit differs from the value that was read.

The block also returns the final permission set for the translation cache. For any access that is not a store, it takes write permission away. A later store to the same page then misses in the cache and comes back through this block, which sets the change bit at that point. When no write-back is needed, the block finishes in a single cycle. Otherwise it holds a valid/ready write request on its memory port until the request is accepted, and then pulses done. The walker does not start the block for a translation that faulted.

Top module: `pte_rc_writer`

## Requirements
- R1: Every write request carries the leaf entry with the reference bit, bit 8 (0x100), set to 1.
- R2: In the written value, the change bit, bit 7 (0x80), is 1 for a store (access kind 2'd1). For a load (2'd0) or a fetch (2'd2), bit 7 keeps its original value. All bits other than 8 and 7 equal the original entry.
- R3: The permission output uses bit 0 for read, bit 1 for write and bit 2 for execute. For a non-store access it equals the granted set with bit 1 cleared. For a store it equals the granted set unchanged.
- R4: When the updated entry equals the original entry, no write request is raised and done is high in the cycle after start.
- R5: When the updated entry differs from the original, wr_valid rises in the cycle after start with wr_addr equal to the entry's address. wr_valid, wr_addr and wr_data then hold steady until a cycle in which wr_ready is high.
- R6: done is high for exactly one cycle. That cycle follows the cycle in which the write request was accepted, and wr_valid is low during it.
- R7: A start that arrives while a write request is pending is ignored. The pending request and the permission output that is later reported both stay those of the first access.
- R8: After reset, wr_valid, done and the permission output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an update for the presented entry |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| entry_in | input | 64 | Leaf entry value as read |
| entry_addr | input | AW | Memory address of the leaf entry |
| perm_in | input | 3 | Granted permissions {exec, write, read} |
| perm_out | output | 3 | Final permissions for the translation cache |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | AW | Write address |
| wr_data | output | 64 | Updated entry value |

## Verification
A stale pending flag would show up as wr_valid stuck high or never rising, or as done missing. Either is visible within one cycle of the start or of the acceptance. A wrongly captured entry or permission register shows up on wr_data, wr_addr or perm_out from the cycle after start, and it must stay correct through ready stalls and any ignored start. A wrong bit mask shows up the first time an entry with the reference bit already set, or a load on an already-changed page, skips or forces a write-back.

// File: rtl/pte_rc_writer.sv
module pte_rc_writer #(
  parameter int AW      = 56,
  parameter int REF_BIT = 8,
  parameter int CHG_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    acc_kind,
  input  logic [63:0]   entry_in,
  input  logic [AW-1:0] entry_addr,
  input  logic [2:0]    perm_in,
  output logic [2:0]    perm_out,
  output logic          done,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [63:0]   wr_data
);

  localparam logic [1:0]  KIND_STORE = 2'd1;
  localparam logic [63:0] REF_MASK   = 64'd1 << REF_BIT;
  localparam logic [63:0] CHG_MASK   = 64'd1 << CHG_BIT;

  logic          is_store;
  logic [63:0]   next_entry;
  logic [2:0]    perm_granted;
  logic          needs_write;
  logic          pend;
  logic [2:0]    perm_q;
  logic [63:0]   data_q;
  logic [AW-1:0] addr_q;

  assign is_store     = (acc_kind == KIND_STORE);
  assign next_entry   = entry_in | REF_MASK | (is_store ? CHG_MASK : 64'd0);
  assign perm_granted = is_store ? perm_in : (perm_in & 3'b101);
  assign needs_write  = (next_entry != entry_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      done   <= 1'b0;
      perm_q <= '0;
      data_q <= '0;
      addr_q <= '0;
    end else begin
      done <= 1'b0;
      if (pend) begin
        if (wr_ready) begin
          pend <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        perm_q <= perm_granted;
        data_q <= next_entry;
        addr_q <= entry_addr;
        if (needs_write) pend <= 1'b1;
        else             done <= 1'b1;
      end
    end
  end

  assign wr_valid = pend;
  assign wr_data  = data_q;
  assign wr_addr  = addr_q;
  assign perm_out = perm_q;

  AST_REF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_valid |-> wr_data[REF_BIT]); // R1
  AST_CHG_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n) (start && !wr_valid && acc_kind == KIND_STORE) |=> (done || wr_data[CHG_BIT])); // R2
  AST_NO_WR_PERM: assert property (@(posedge clk) disable iff (!rst_n) (start && !wr_valid && acc_kind != KIND_STORE) |=> !perm_out[1]); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr) && $stable(perm_out))); // R5
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (wr_valid && wr_ready) |=> (done && !wr_valid)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6

endmodule

// File: tb/pte_rc_writer_bench.sv
module pte_rc_writer_bench;
  localparam int AW = 56;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    acc_kind = 2'd0;
  logic [63:0]   entry_in = '0;
  logic [AW-1:0] entry_addr = '0;
  logic [2:0]    perm_in = '0;
  logic [2:0]    perm_out;
  logic          done;
  logic          wr_valid;
  logic          wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [63:0]   wr_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pte_rc_writer #(.AW(AW)) u_pte_rc_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_kind(acc_kind),
    .entry_in(entry_in), .entry_addr(entry_addr), .perm_in(perm_in),
    .perm_out(perm_out), .done(done), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_entry(input logic [1:0] k, input logic [63:0] e);
    return e | 64'h100 | ((k == 2'd1) ? 64'h80 : 64'h0);
  endfunction

  function automatic logic [2:0] exp_perm(input logic [1:0] k, input logic [2:0] p);
    return (k == 2'd1) ? p : (p & 3'b101);
  endfunction

  task automatic access(input logic [1:0] k, input logic [63:0] e, input logic [AW-1:0] a,
                        input logic [2:0] p, input int stall, input bit poke);
    logic [63:0] ne;
    ne = exp_entry(k, e);
    @(negedge clk);
    start = 1'b1; acc_kind = k; entry_in = e; entry_addr = a; perm_in = p;
    @(negedge clk);
    start = 1'b0;
    if (ne == e) begin
      chk(done == 1'b1, "R4 done next cycle", 64'(done), 64'd1);
      chk(wr_valid == 1'b0, "R4 no write", 64'(wr_valid), 64'd0);
      chk(perm_out == exp_perm(k, p), "R3 perm", 64'(perm_out), 64'(exp_perm(k, p)));
    end else begin
      chk(wr_valid == 1'b1, "R5 valid", 64'(wr_valid), 64'd1);
      chk(wr_addr == a, "R5 addr", 64'(wr_addr), 64'(a));
      chk(wr_data[8] == 1'b1, "R1 ref bit", wr_data, ne);
      chk(wr_data == ne, "R2 data", wr_data, ne);
      chk(done == 1'b0, "R6 no early done", 64'(done), 64'd0);
      for (int i = 0; i < stall; i++) begin
        if (poke && i == 0) begin
          start = 1'b1; acc_kind = 2'd1; entry_in = 64'h0; entry_addr = '1; perm_in = 3'b111;
        end
        @(negedge clk);
        start = 1'b0;
        chk(wr_valid == 1'b1 && wr_data == ne && wr_addr == a, "R5/R7 hold", wr_data, ne);
      end
      wr_ready = 1'b1;
      @(negedge clk);
      wr_ready = 1'b0;
      chk(done == 1'b1, "R6 done", 64'(done), 64'd1);
      chk(wr_valid == 1'b0, "R6 valid dropped", 64'(wr_valid), 64'd0);
      chk(perm_out == exp_perm(k, p), "R3/R7 perm", 64'(perm_out), 64'(exp_perm(k, p)));
    end
    @(negedge clk);
    chk(done == 1'b0, "R6 single pulse", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(wr_valid == 1'b0 && done == 1'b0 && perm_out == 3'b000, "R8 reset",
        {61'd0, wr_valid, done, |perm_out}, 64'd0);
  endtask

  task automatic t_load_fresh;  access(2'd0, 64'hC000_0000_0123_4005, 56'h12_3450, 3'b011, 0, 0); endtask
  task automatic t_fetch;       access(2'd2, 64'hC000_0000_0ABC_0001, 56'h00_1238, 3'b111, 2, 0); endtask
  task automatic t_load_keepc;  access(2'd0, 64'hC000_0000_0555_0086, 56'h00_0040, 3'b011, 1, 0); endtask
  task automatic t_store;       access(2'd1, 64'hC000_0000_0777_0106, 56'h0F_FFF8, 3'b011, 3, 0); endtask
  task automatic t_load_noop;   access(2'd0, 64'hC000_0000_0999_0104, 56'h00_0100, 3'b111, 0, 0); endtask
  task automatic t_store_noop;  access(2'd1, 64'hC000_0000_0999_0186, 56'h00_0108, 3'b011, 0, 0); endtask
  task automatic t_busy_start;  access(2'd2, 64'hC000_0000_0321_0005, 56'hAB_CDE0, 3'b101, 3, 1); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_fresh();
    t_fetch();
    t_load_keepc();
    t_store();
    t_load_noop();
    t_store_noop();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule